// File: doc/BRIEF.md
# E1 Payload Loopback Multiplexer

This block sits between an E1 receive path and an E1 transmit path. It works on a serial 2.048 Mbit/s stream that carries one bit per clock. Each frame holds 32 time slots of eight bits. In normal operation the line transmitter sends the system's transmit data. When payload loopback is on, the received stream goes back to the line in place of the system data. The received stream has already passed the elastic store.

During loopback, time slot 0 has two modes. In the first, a local generator rebuilds it. Even frames carry the alignment word and odd frames carry the non-alignment word. In the second, the received time slot 0 is passed through unchanged. The received data still reaches the system side. The system-side copy can be replaced by all ones (AIS) while the loop is active. A clock-select output tells the transmit stage to run from the receive clock while the loop is active.

Control inputs are sampled only on the first bit of a frame, so every frame on either output is built under one setting. A frame marker from the receive framer aligns an internal bit position counter. If the marker is missing, the counter keeps running and wraps after 256 bits.

Top module: `e1_payload_loop`

## Requirements
- R1: With loopback inactive, `line_tx_bit` equals the `sys_tx_bit` value of the previous cycle.
- R2: With loopback active, every bit outside time slot 0 on `line_tx_bit` equals the `rx_bit` of the previous cycle, and `sys_tx_bit` has no effect.
- R3: With loopback active and transparent mode off, time slot 0 carries a locally generated word, sent first bit first. Even frames carry 1,0,0,1,1,0,1,1 and odd frames carry 1,1,0,1,1,1,1,1. The first marked frame after reset counts as even, and the frame parity toggles at every frame start.
- R4: With loopback active and transparent mode on, the time slot 0 bits on `line_tx_bit` equal the received bits of the previous cycle.
- R5: With loopback and AIS both active, `sys_rx_bit` is 1. Otherwise `sys_rx_bit` equals the `rx_bit` of the previous cycle.
- R6: With loopback inactive, `ais_en` has no effect on `sys_rx_bit`.
- R7: `tx_clk_from_rx` is 1 exactly while the output bit was produced with loopback active.
- R8: `loop_en`, `ais_en` and `ts0_transparent` are sampled only in a cycle with `rx_frame_start` high. Their values in any other cycle have no effect.
- R9: `rx_frame_start` marks bit 0 of slot 0. The slot is the bit position divided by 8. Without a marker, the position wraps from 255 to 0, and that wrap also starts a new frame for the parity count.
- R10: During reset and in the first cycle after it, all outputs are 0 and loopback is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (receive side) |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received data, after the elastic store |
| rx_frame_start | input | 1 | High on bit 0 of time slot 0 |
| sys_tx_bit | input | 1 | System transmit data |
| loop_en | input | 1 | Payload loopback enable |
| ais_en | input | 1 | Replace system receive data with all ones during loopback |
| ts0_transparent | input | 1 | Loop the received time slot 0 instead of generating it |
| line_tx_bit | output | 1 | Transmit data to the line, one cycle latency |
| sys_rx_bit | output | 1 | Receive data to the system, one cycle latency |
| tx_clk_from_rx | output | 1 | 1: transmit runs from the receive clock |

## Verification
Embedded assertions check these properties on every cycle:
- the pass-through of system data while loopback is off;
- the looping of payload bits while it is on;
- the all-ones substitution;
- that neither the clock select nor the latched controls can change except just after a frame start.

Some behaviours only the bench's scenarios can show. These are the exact alignment and non-alignment words and their even/odd alternation, transparent time slot 0, and the counter wrap when markers are missing. Controls toggled at random mid-frame are compared against an independent frame-position model.

// File: rtl/e1pl_pkg.sv
package e1pl_pkg;
    localparam int WORD_BITS = 8;
    // bit index 7 is sent first
    localparam logic [WORD_BITS-1:0] ALIGN_WORD    = 8'b1001_1011;
    localparam logic [WORD_BITS-1:0] NONALIGN_WORD = 8'b1101_1111;

    typedef struct packed {
        logic loop;
        logic ais;
        logic transp;
    } loop_ctl_t;
endpackage

// File: rtl/e1pl_slot_tracker.sv
module e1pl_slot_tracker #(
    parameter int SLOTS = 32,
    parameter int BITS  = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BIT_W  = $clog2(BITS),
    localparam int POS_W  = SLOT_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [BIT_W-1:0]  cur_bit,
    output logic              cur_odd
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOTS * BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             odd;
    } trk_t;

    trk_t st_d, st_q;
    logic [POS_W-1:0] pos_now;
    logic             odd_now;
    logic             wrapped_q;

    always_comb begin
        pos_now  = frame_start ? '0 : st_q.pos;
        odd_now  = (frame_start || wrapped_q) ? ~st_q.odd : st_q.odd;
        st_d.pos = (pos_now == LAST_POS) ? '0 : pos_now + 1'b1;
        st_d.odd = odd_now;
        cur_slot = pos_now[POS_W-1:BIT_W];
        cur_bit  = pos_now[BIT_W-1:0];
        cur_odd  = odd_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pos  <= '0;
            st_q.odd  <= 1'b1;
            wrapped_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            wrapped_q <= (pos_now == LAST_POS) && !frame_start;
        end
    end

    // R9
    frame_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (st_q.pos == POS_W'(1)));
endmodule

// File: rtl/e1pl_ctl_latch.sv
module e1pl_ctl_latch
    import e1pl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frame_start,
    input  loop_ctl_t ctl_in,
    output loop_ctl_t ctl_act
);
    loop_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d   = frame_start ? ctl_in : ctl_q;
        ctl_act = ctl_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // R8
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(ctl_q));
endmodule

// File: rtl/e1pl_ts0_gen.sv
module e1pl_ts0_gen
    import e1pl_pkg::*;
#(
    parameter int BITS = WORD_BITS,
    localparam int BIT_W = $clog2(BITS)
) (
    input  logic             odd_frame,
    input  logic [BIT_W-1:0] bit_idx,
    output logic             gen_bit
);
    logic [BIT_W-1:0]     sel;
    logic [WORD_BITS-1:0] word;

    always_comb begin
        sel     = BIT_W'(BITS - 1) - bit_idx;
        word    = odd_frame ? NONALIGN_WORD : ALIGN_WORD;
        gen_bit = word[sel];
    end
endmodule

// File: rtl/e1_payload_loop.sv
module e1_payload_loop
    import e1pl_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int BITS  = WORD_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic rx_frame_start,
    input  logic sys_tx_bit,
    input  logic loop_en,
    input  logic ais_en,
    input  logic ts0_transparent,
    output logic line_tx_bit,
    output logic sys_rx_bit,
    output logic tx_clk_from_rx
);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(BITS);

    typedef struct packed {
        logic line;
        logic sysrx;
        logic sel;
    } out_t;

    out_t             out_d, out_q;
    loop_ctl_t        ctl_in, act;
    logic [SLOT_W-1:0] slot;
    logic [BIT_W-1:0]  bidx;
    logic             odd, gen_bit, in_ts0;

    assign ctl_in = '{loop: loop_en, ais: ais_en, transp: ts0_transparent};

    e1pl_slot_tracker #(.SLOTS(SLOTS), .BITS(BITS)) u_trk (
        .clk(clk), .rst_n(rst_n), .frame_start(rx_frame_start),
        .cur_slot(slot), .cur_bit(bidx), .cur_odd(odd));

    e1pl_ctl_latch u_ctl (
        .clk(clk), .rst_n(rst_n), .frame_start(rx_frame_start),
        .ctl_in(ctl_in), .ctl_act(act));

    e1pl_ts0_gen #(.BITS(BITS)) u_gen (
        .odd_frame(odd), .bit_idx(bidx), .gen_bit(gen_bit));

    always_comb begin
        in_ts0 = (slot == '0);
        out_d.sel = act.loop;
        if (!act.loop)                  out_d.line = sys_tx_bit;
        else if (in_ts0 && !act.transp) out_d.line = gen_bit;
        else                            out_d.line = rx_bit;
        out_d.sysrx = (act.loop && act.ais) ? 1'b1 : rx_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign line_tx_bit    = out_q.line;
    assign sys_rx_bit     = out_q.sysrx;
    assign tx_clk_from_rx = out_q.sel;

    // R1
    sys_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !tx_clk_from_rx |-> line_tx_bit == $past(sys_tx_bit));
    // R2
    payload_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && tx_clk_from_rx && $past(slot != '0) |-> line_tx_bit == $past(rx_bit));
    // R5
    ais_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(act.loop && act.ais) |-> sys_rx_bit);
    // R7
    sel_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(rx_frame_start) |-> $stable(tx_clk_from_rx));
endmodule

// File: tb/e1_payload_loop_tb.sv
module e1_payload_loop_tb;
    logic clk = 0, rst_n = 0;
    logic rx_bit = 0, rx_frame_start = 0, sys_tx_bit = 0;
    logic loop_en = 0, ais_en = 0, ts0_transparent = 0;
    logic line_tx_bit, sys_rx_bit, tx_clk_from_rx;

    e1_payload_loop u_dut (.*);

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    string phase = "init";

    // reference model state
    int  m_pos = 0;
    bit  m_odd = 1, m_wrap = 0;
    bit  m_loop = 0, m_ais = 0, m_tr = 0;
    bit  have_exp = 0;
    bit  e_line, e_sysrx, e_sel;
    string r_line, r_sysrx;

    function automatic bit gen_ts0(bit odd, int b);
        bit [7:0] w;
        w = odd ? 8'b1101_1111 : 8'b1001_1011;
        return w[7-b];
    endfunction

    task automatic chk(string req, bit got, bit exp, string what);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s got %0b expected %0b", req, phase, what, got, exp);
        end
    endtask

    // check last cycle, then drive one bit and predict its result
    task automatic step(bit fs, bit cl, bit ca, bit ct);
        int cur;
        bit odd;
        bit rb, sb;
        @(negedge clk);
        if (have_exp) begin
            chk(r_line, line_tx_bit, e_line, "line_tx_bit");
            chk(r_sysrx, sys_rx_bit, e_sysrx, "sys_rx_bit");
            chk("R7", tx_clk_from_rx, e_sel, "tx_clk_from_rx");
        end
        rb = 1'($urandom); sb = 1'($urandom);
        rx_bit = rb; sys_tx_bit = sb; rx_frame_start = fs;
        loop_en = cl; ais_en = ca; ts0_transparent = ct;
        cur = fs ? 0 : m_pos;
        odd = (fs || m_wrap) ? !m_odd : m_odd;
        if (fs) begin m_loop = cl; m_ais = ca; m_tr = ct; end
        if (!m_loop) begin e_line = sb; r_line = "R1"; end
        else if (cur / 8 == 0 && !m_tr) begin e_line = gen_ts0(odd, cur % 8); r_line = "R3"; end
        else if (cur / 8 == 0) begin e_line = rb; r_line = "R4"; end
        else begin e_line = rb; r_line = "R2"; end
        e_sysrx = (m_loop && m_ais) ? 1'b1 : rb;
        r_sysrx = m_loop ? "R5" : "R6";
        e_sel = m_loop;
        m_wrap = (cur == 255) && !fs;
        m_pos = (cur + 1) % 256;
        m_odd = odd;
        have_exp = 1;
    endtask

    task automatic run_frames(int n, bit marker, bit cl, bit ca, bit ct, bit rnd_ctl);
        for (int f = 0; f < n; f++)
            for (int p = 0; p < 256; p++) begin
                if (rnd_ctl)
                    step(marker && p == 0, 1'($urandom), 1'($urandom), 1'($urandom));
                else
                    step(marker && p == 0, cl, ca, ct);
            end
    endtask

    initial begin
        void'($urandom(32'd2255));
        repeat (4) @(negedge clk);
        phase = "reset";
        chk("R10", line_tx_bit, 1'b0, "line_tx_bit in reset");
        chk("R10", sys_rx_bit, 1'b0, "sys_rx_bit in reset");
        chk("R10", tx_clk_from_rx, 1'b0, "tx_clk_from_rx in reset");
        rst_n = 1;
        @(negedge clk);
        chk("R10", tx_clk_from_rx, 1'b0, "tx_clk_from_rx after reset");
        chk("R10", line_tx_bit, 1'b0, "line_tx_bit after reset");
        phase = "R1_R6"; run_frames(2, 1, 0, 1, 0, 0);
        phase = "R2_R3"; run_frames(4, 1, 1, 0, 0, 0);
        phase = "R4";    run_frames(2, 1, 1, 0, 1, 0);
        phase = "R5";    run_frames(2, 1, 1, 1, 0, 0);
        // R8: controls change every cycle, only frame-start values count
        phase = "R8";    run_frames(4, 1, 0, 0, 0, 1);
        phase = "R2_R3b"; run_frames(1, 1, 1, 0, 0, 0);
        // R9: markers missing, position and parity run on by wrapping
        phase = "R9";    run_frames(3, 0, 0, 0, 0, 0);
        phase = "R1b";   run_frames(2, 1, 0, 0, 1, 0);
        step(1, 0, 0, 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule